// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps the time of day for a twelve-hour clock display. A one-cycle tick, normally produced once per second by a divider elsewhere in the chip, advances a seconds field. When the seconds field rolls over it carries into a minutes field. When both the minutes and the seconds fields roll over together, the carry moves into an hours field. Each field is given out as two BCD digits, so a display decoder can use them directly.

The seconds and minutes fields are each built the same way: a units digit that counts through ten values, followed by a tens digit that counts through six. The tens digit advances only on the tick that wraps its units digit. The hours field has its own wrap logic. It counts 1 through 12 and then returns to 1, so it never shows zero. Reset sets the display to 12:00:00.

Top module: `twelve_hour_clock`

## Requirements
- R1: With `rst` high at a clock edge, the outputs show 12:00:00 after that edge (hour tens 1, hour units 2, every other digit 0). This holds both at power-up and when reset is raised partway through a count.
- R2: A clock edge with `tick` high raises the seconds units digit by one. The new value is visible after that edge. Back-to-back ticks on successive cycles each count once.
- R3: The seconds units digit counts 0 to 9. On the tick that takes it from 9 to 0, the seconds tens digit goes up by one. The seconds tens digit counts 0 to 5, so the seconds field goes from 59 to 00.
- R4: The minutes field changes only on a tick that finds the seconds field at 59. On that tick the minutes field steps by one. It uses the same 0-9 units and 0-5 tens digits, so 59 goes to 00.
- R5: The hours field changes only on a tick that finds both the minutes and the seconds fields at 59.
- R6: The hours field goes 01 to 09, then 10, 11, 12, and then back to 01. It never shows 00.
- R7: Every digit is a 4-bit binary value, with bit 0 as the least significant bit, and is never above 9. The hour tens digit is only ever 0 or 1.
- R8: A clock edge with `tick` low leaves every digit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to 12:00:00 |
| tick | input | 1 | One-second advance pulse, sampled on each rising edge |
| sec_units | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD 0-5 |
| min_units | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD 0-5 |
| hr_units | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, 0 or 1 |

## Verification
The counter is driven with single ticks, short bursts that stop exactly on each carry boundary, and long runs of back-to-back ticks that cross whole hours. Single ticks confirm that a units digit steps by one. Stopping at x9, at 59 and at 59:59 separates a correct carry from an early or missing carry into the next digit. Runs that end at 09:59:59 → 10:00:00 and at 12:59:59 → 01:00:00 separate the hours decade step from the twelve-to-one wrap. Idle stretches with no tick, and a reset raised partway through a run, show that the count holds when idle and returns to 12:00:00 on reset.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } field_t;

    localparam bcd_t HR_RESET_TENS  = 4'd1;
    localparam bcd_t HR_RESET_UNITS = 4'd2;

    function automatic logic field_is_59(field_t f);
        return (f.tens == 4'd5) && (f.units == 4'd9);
    endfunction

endpackage

// File: rtl/bcd_digit_ctr.sv
module bcd_digit_ctr
    import clk12_pkg::*;
#(
    parameter int LAST = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output bcd_t q,
    output logic wrap
);
    localparam bcd_t LAST_V = bcd_t'(LAST);

    bcd_t cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == LAST_V) ? '0 : cnt + 4'd1;
    end

    assign q    = cnt;
    assign wrap = en && (cnt == LAST_V);

    // R3/R7: a digit never goes past its last value
    a_r7_digit_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_V);

    // R8: without enable the digit holds
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    // R3: stepping from the last value lands on zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == LAST_V) |=> cnt == '0);

endmodule

// File: rtl/sixty_stage.sv
module sixty_stage
    import clk12_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output field_t val,
    output logic   wrap
);
    logic units_wrap;

    bcd_digit_ctr #(.LAST(9)) u_units (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .q   (val.units),
        .wrap(units_wrap)
    );

    bcd_digit_ctr #(.LAST(5)) u_tens (
        .clk (clk),
        .rst (rst),
        .en  (units_wrap),
        .q   (val.tens),
        .wrap(wrap)
    );

endmodule

// File: rtl/hour_stage.sv
module hour_stage
    import clk12_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output field_t val
);
    field_t hr;
    logic   at_twelve;
    logic   at_nine;

    assign at_twelve = (hr.tens == 4'd1) && (hr.units == 4'd2);
    assign at_nine   = (hr.units == 4'd9);

    always_ff @(posedge clk) begin
        if (rst) begin
            hr.tens  <= HR_RESET_TENS;
            hr.units <= HR_RESET_UNITS;
        end else if (en) begin
            if (at_twelve) begin
                hr.tens  <= 4'd0;
                hr.units <= 4'd1;
            end else if (at_nine) begin
                hr.tens  <= 4'd1;
                hr.units <= 4'd0;
            end else begin
                hr.units <= hr.units + 4'd1;
            end
        end
    end

    assign val = hr;

    // R6: twelve goes to one
    a_r6_twelve_to_one: assert property (@(posedge clk) disable iff (rst)
        (en && at_twelve) |=> (val.tens == 4'd0 && val.units == 4'd1));

    // R6: the hours field never reads 00
    a_r6_never_zero: assert property (@(posedge clk) disable iff (rst)
        !(val.tens == 4'd0 && val.units == 4'd0));

    // R7: the hour tens digit is 0 or 1 and the hour stays at or below 12
    a_r7_hour_legal: assert property (@(posedge clk) disable iff (rst)
        (val.tens <= 4'd1) && (val.units <= 4'd9) &&
        !(val.tens == 4'd1 && val.units > 4'd2));

endmodule

// File: rtl/twelve_hour_clock.sv
module twelve_hour_clock
    import clk12_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output logic [3:0] sec_units,
    output logic [3:0] sec_tens,
    output logic [3:0] min_units,
    output logic [3:0] min_tens,
    output logic [3:0] hr_units,
    output logic [3:0] hr_tens
);
    field_t secs;
    field_t mins;
    field_t hrs;
    logic   sec_wrap;
    logic   min_wrap;

    sixty_stage u_sec (
        .clk (clk),
        .rst (rst),
        .en  (tick),
        .val (secs),
        .wrap(sec_wrap)
    );

    sixty_stage u_min (
        .clk (clk),
        .rst (rst),
        .en  (sec_wrap),
        .val (mins),
        .wrap(min_wrap)
    );

    hour_stage u_hr (
        .clk(clk),
        .rst(rst),
        .en (min_wrap),
        .val(hrs)
    );

    assign sec_units = secs.units;
    assign sec_tens  = secs.tens;
    assign min_units = mins.units;
    assign min_tens  = mins.tens;
    assign hr_units  = hrs.units;
    assign hr_tens   = hrs.tens;

    // R4: minutes move only on a tick that finds seconds at 59
    a_r4_min_needs_sec59: assert property (@(posedge clk) disable iff (rst)
        !(tick && field_is_59(secs)) |=> $stable(mins));

    // R5: hours move only on a tick that finds 59:59
    a_r5_hr_needs_5959: assert property (@(posedge clk) disable iff (rst)
        !(tick && field_is_59(secs) && field_is_59(mins)) |=> $stable(hrs));

    // R1: reset produces 12:00:00
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (hrs.tens == 4'd1 && hrs.units == 4'd2 &&
                 mins == '0 && secs == '0));

endmodule

// File: tb/twelve_hour_clock_tb.sv
module twelve_hour_clock_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] sec_units, sec_tens, min_units, min_tens, hr_units, hr_tens;

    int n_checks = 0;
    int n_bad    = 0;

    always #2 clk = ~clk;

    twelve_hour_clock u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sec_units(sec_units),
        .sec_tens (sec_tens),
        .min_units(min_units),
        .min_tens (min_tens),
        .hr_units (hr_units),
        .hr_tens  (hr_tens)
    );

    typedef struct packed {
        logic [31:0] ticks;
        logic [23:0] want;
        logic [7:0]  req;
    } vec_t;

    // ticks applied back to back, then the expected time as HHMMSS in BCD
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'd1,     24'h120001, 8'd2},
        '{32'd8,     24'h120009, 8'd2},
        '{32'd1,     24'h120010, 8'd3},
        '{32'd49,    24'h120059, 8'd3},
        '{32'd1,     24'h120100, 8'd4},
        '{32'd3538,  24'h125958, 8'd4},
        '{32'd1,     24'h125959, 8'd5},
        '{32'd1,     24'h010000, 8'd6},
        '{32'd32399, 24'h095959, 8'd5},
        '{32'd1,     24'h100000, 8'd6},
        '{32'd10800, 24'h010000, 8'd6}
    };

    function automatic logic [23:0] now();
        return {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
    endfunction

    task automatic check(input logic [23:0] exp, input int req);
        n_checks++;
        if (now() !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, now(), exp);
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
        end
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check(24'h120000, 1);              // R1 power-up value

        idle(5);
        check(24'h120000, 8);              // R8 no tick, no change

        for (int v = 0; v < NV; v++) begin
            run_ticks(int'(VECS[v].ticks));
            check(VECS[v].want, int'(VECS[v].req));
            // R7 hour tens must be 0 or 1, digits at most 9
            n_checks++;
            if (hr_tens > 4'd1 || sec_units > 4'd9 || min_units > 4'd9 || hr_units > 4'd9) begin
                n_bad++;
                $display("FAIL R7: got %h expected legal BCD", now());
            end
        end

        idle(7);
        check(24'h010000, 8);              // R8 idle after a run

        // R2 single spaced pulses each count once
        for (int i = 0; i < 3; i++) begin
            run_ticks(1);
            idle(2);
        end
        check(24'h010003, 2);

        // R1 reset partway through a count
        run_ticks(100);
        check(24'h010143, 4);              // R4 minutes stepped once
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check(24'h120000, 1);

        // R1 reset has priority over a simultaneous tick
        @(negedge clk) begin rst = 1'b1; tick = 1'b1; end
        @(negedge clk) begin rst = 1'b0; tick = 1'b0; end
        check(24'h120000, 1);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule